// File: doc/BRIEF.md
# Serial EEPROM Slave Write Front-End

This block is the bus-side protocol engine of a two-wire serial EEPROM slave, and it handles only the write path. It oversamples SCL and SDA on the system clock and detects Start and Stop conditions. It shifts in a select byte followed by a 16-bit byte address, sent high byte first. It answers each byte by pulling SDA low through an open-drain output enable. Each accepted data byte goes to a page-write engine together with its target address. A one-cycle commit strobe tells that engine to start its internal write cycle.

Writes can be blocked by a write-protect input, which is watched from the Start until the end of the second address byte. While the page engine reports busy, the slave stays off the bus completely. A repeated Start drops any data that has not been committed and restarts select decoding.

Top module: `eewr_front`

## Requirements
- R1: After reset, `sda_oe_o`, `wr_vld_o` and `commit_o` are all 0.
- R2: The first byte after a Start is acknowledged only when bits 7:4 equal 4'b1010, bits 3:1 equal `chip_addr_i`, and bit 0 (read/write) is 0. Otherwise that byte and every later byte get no acknowledge until the next Start.
- R3: The two bytes after an accepted select byte form the address, high byte first. Each of them is acknowledged.
- R4: In a write that is not protected, each data byte is acknowledged and presented on `wr_data_o` with a one-cycle `wr_vld_o` pulse. The address of the n-th byte (n from 0) keeps the row bits above log2(PAGE_BYTES) from the received address. Its column is the received column plus n, modulo PAGE_BYTES.
- R5: If `wp_i` is high on any cycle from the Start through the end of the second address byte, every data byte gets no acknowledge. In that case `wr_vld_o` and `commit_o` stay 0.
- R6: A `wp_i` that goes high only after the second address byte has no effect on the transfer.
- R7: A Stop in the bit slot right after the acknowledge of a data byte pulses `commit_o` for one cycle. This needs an unprotected transfer with at least one accepted data byte.
- R8: A Stop at any other bit position, or before any data byte, produces no commit.
- R9: A repeated Start returns the slave to select decoding and discards uncommitted data, so no commit follows for it.
- R10: While `busy_i` is high, `sda_oe_o` stays 0 and no byte is accepted or committed.
- R11: The acknowledge is held through the 9th SCL high period and released after the following SCL falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (acknowledge) |
| chip_addr_i | input | 3 | Strapped chip-enable address |
| wp_i | input | 1 | Write-protect level |
| busy_i | input | 1 | Page engine internal write cycle in progress |
| wr_addr_o | output | 16 | Byte address of presented data |
| wr_data_o | output | 8 | Presented data byte |
| wr_vld_o | output | 1 | One-cycle data strobe |
| commit_o | output | 1 | One-cycle write-cycle trigger |

## Verification
The bench builds the block with PAGE_BYTES = 4 and SYNC_STAGES = 2. The small page means a transfer of only five bytes wraps the column, so the roll-over rule of R4 is covered in a short run. Each bus quarter-period is eight system clocks, which leaves room for the synchronizer delay before acknowledge sampling. The cases covered are:
- mid-byte Stops and a Stop straight after the address, to show that commit is tied to the bit position;
- a write-protect pulse during select only, to show the sampling window;
- a busy write cycle, during which the slave must stay off the bus.

// File: rtl/eewr_pkg.sv
package eewr_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned BYTE_W = 8;
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_AHI,
    ST_ALO,
    ST_DATA,
    ST_SKIP
  } eewr_state_e;
endpackage

// File: rtl/eewr_bus_sync.sv
module eewr_bus_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
  logic scl_s, sda_s, scl_q, sda_q;

  assign scl_s = scl_ff[SYNC_STAGES-1];
  assign sda_s = sda_ff[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  // SDA edges while SCL stays high
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/eewr_bit_ctr.sv
module eewr_bit_ctr
  import eewr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic [3:0]        bit_cnt_o,
  output logic              byte_done_o,
  output logic              ack_end_o
);
  localparam logic [3:0] LAST_BIT = 4'(BYTE_W);

  logic [BYTE_W-1:0] sreg_q;
  logic [3:0]        cnt_q;
  logic              ack_hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q   <= '0;
      cnt_q    <= '0;
      ack_hi_q <= 1'b0;
    end else if (start_i || stop_i) begin
      cnt_q    <= '0;
      ack_hi_q <= 1'b0;
    end else if (scl_rise_i) begin
      if (cnt_q < LAST_BIT) begin
        sreg_q <= {sreg_q[BYTE_W-2:0], sda_i};
        cnt_q  <= cnt_q + 4'd1;
      end else begin
        ack_hi_q <= 1'b1;
      end
    end else if (scl_fall_i && ack_hi_q) begin
      cnt_q    <= '0;
      ack_hi_q <= 1'b0;
    end
  end

  assign byte_o      = sreg_q;
  assign bit_cnt_o   = cnt_q;
  assign byte_done_o = scl_fall_i & (cnt_q == LAST_BIT) & ~ack_hi_q;
  assign ack_end_o   = scl_fall_i & ack_hi_q;

  a_r11_ack_slot_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_hi_q |-> cnt_q == LAST_BIT);
endmodule

// File: rtl/eewr_ctrl.sv
module eewr_ctrl
  import eewr_pkg::*;
#(
  parameter int unsigned PAGE_BYTES = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [3:0]        bit_cnt_i,
  input  logic              byte_done_i,
  input  logic              ack_end_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [2:0]        chip_addr_i,
  input  logic              wp_i,
  input  logic              busy_i,
  output logic              sda_oe_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              wr_vld_o,
  output logic              commit_o
);
  localparam int unsigned PW = $clog2(PAGE_BYTES);

  eewr_state_e       state_q;
  logic              inhibit_q, have_q, oe_q, vld_q, commit_q;
  logic [ADDR_W-1:0] base_q, waddr_q;
  logic [PW-1:0]     idx_q;
  logic [BYTE_W-1:0] data_q;
  logic              sel_match, addr_phase, commit_ok;
  logic [PW-1:0]     col;

  assign sel_match  = (byte_i[7:4] == DEV_TYPE) && (byte_i[3:1] == chip_addr_i) && !byte_i[0];
  assign addr_phase = (state_q == ST_SEL) || (state_q == ST_AHI) || (state_q == ST_ALO);
  assign commit_ok  = (state_q == ST_DATA) && (bit_cnt_i == 4'd1) && have_q && !inhibit_q;
  assign col        = base_q[PW-1:0] + idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      inhibit_q <= 1'b0;
      have_q    <= 1'b0;
      oe_q      <= 1'b0;
      vld_q     <= 1'b0;
      commit_q  <= 1'b0;
      base_q    <= '0;
      waddr_q   <= '0;
      idx_q     <= '0;
      data_q    <= '0;
    end else begin
      vld_q    <= 1'b0;
      commit_q <= 1'b0;
      if (busy_i) begin
        state_q <= ST_IDLE;
        oe_q    <= 1'b0;
        have_q  <= 1'b0;
      end else if (start_i) begin
        state_q   <= ST_SEL;
        inhibit_q <= wp_i;
        have_q    <= 1'b0;
        idx_q     <= '0;
        oe_q      <= 1'b0;
      end else if (stop_i) begin
        commit_q <= commit_ok;
        state_q  <= ST_IDLE;
        oe_q     <= 1'b0;
        have_q   <= 1'b0;
      end else begin
        if (addr_phase && wp_i) inhibit_q <= 1'b1;
        if (ack_end_i) oe_q <= 1'b0;
        if (byte_done_i) begin
          unique case (state_q)
            ST_SEL: begin
              oe_q    <= sel_match;
              state_q <= sel_match ? ST_AHI : ST_SKIP;
            end
            ST_AHI: begin
              base_q[ADDR_W-1:BYTE_W] <= byte_i;
              oe_q    <= 1'b1;
              state_q <= ST_ALO;
            end
            ST_ALO: begin
              base_q[BYTE_W-1:0] <= byte_i;
              oe_q    <= 1'b1;
              state_q <= ST_DATA;
            end
            ST_DATA: begin
              if (!inhibit_q) begin
                oe_q    <= 1'b1;
                vld_q   <= 1'b1;
                data_q  <= byte_i;
                waddr_q <= {base_q[ADDR_W-1:PW], col};
                idx_q   <= idx_q + 1'b1;
                have_q  <= 1'b1;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign sda_oe_o  = oe_q;
  assign wr_addr_o = waddr_q;
  assign wr_data_o = data_q;
  assign wr_vld_o  = vld_q;
  assign commit_o  = commit_q;

  a_r5_inhibit_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA && inhibit_q) |=> !vld_q && !commit_q);
  a_r7_commit_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_q |=> !commit_q);
  a_r4_same_row: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> wr_addr_o[ADDR_W-1:PW] == base_q[ADDR_W-1:PW]);
  a_r10_busy_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> !oe_q && !vld_q && !commit_q);
  a_r11_oe_after_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_q) |-> $past(byte_done_i));
endmodule

// File: rtl/eewr_front.sv
module eewr_front
  import eewr_pkg::*;
#(
  parameter int unsigned PAGE_BYTES  = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [2:0]        chip_addr_i,
  input  logic              wp_i,
  input  logic              busy_i,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              wr_vld_o,
  output logic              commit_o
);
  logic              sda_s, scl_rise, scl_fall, start, stop;
  logic [BYTE_W-1:0] rx_byte;
  logic [3:0]        bit_cnt;
  logic              byte_done, ack_end;

  eewr_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start),
    .stop_o     (stop)
  );

  eewr_bit_ctr u_bits (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sda_i       (sda_s),
    .scl_rise_i  (scl_rise),
    .scl_fall_i  (scl_fall),
    .start_i     (start),
    .stop_i      (stop),
    .byte_o      (rx_byte),
    .bit_cnt_o   (bit_cnt),
    .byte_done_o (byte_done),
    .ack_end_o   (ack_end)
  );

  eewr_ctrl #(.PAGE_BYTES(PAGE_BYTES)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .byte_i      (rx_byte),
    .bit_cnt_i   (bit_cnt),
    .byte_done_i (byte_done),
    .ack_end_i   (ack_end),
    .start_i     (start),
    .stop_i      (stop),
    .chip_addr_i (chip_addr_i),
    .wp_i        (wp_i),
    .busy_i      (busy_i),
    .sda_oe_o    (sda_oe_o),
    .wr_addr_o   (wr_addr_o),
    .wr_data_o   (wr_data_o),
    .wr_vld_o    (wr_vld_o),
    .commit_o    (commit_o)
  );
endmodule

// File: tb/eewr_front_tb_top.sv
module eewr_front_tb_top;
  localparam int PAGE = 4;
  localparam int Q    = 8;
  localparam logic [2:0] CHIP = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic wp = 1'b0, busy = 1'b0;
  logic sda_oe, vld, commit;
  logic [15:0] waddr;
  logic [7:0]  wdata;
  logic sda_line;

  int n_chk = 0, n_err = 0, commits_seen = 0, commits_exp = 0;
  logic [23:0] exp_q[$];

  always #5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  eewr_front #(.PAGE_BYTES(PAGE), .SYNC_STAGES(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .chip_addr_i(CHIP), .wp_i(wp), .busy_i(busy),
    .wr_addr_o(waddr), .wr_data_o(wdata), .wr_vld_o(vld), .commit_o(commit)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && vld) begin
      if (exp_q.size() == 0) chk("R4/R5 unexpected write", {8'h0, waddr, wdata}, 32'hFFFFFFFF);
      else chk("R4 write item", {8'h0, waddr, wdata}, {8'h0, exp_q.pop_front()});
    end
    if (rst_n && commit) commits_seen++;
  end

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q);
    sda_m = 1'b1; wq(2*Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0; wq(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked, output logic oe_after);
    send_bits(b, 8);
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
    acked = ~sda_line;
    wq(Q); scl_m = 1'b0; wq(Q);
    oe_after = sda_oe;
  endtask

  task automatic do_write(input logic [7:0] sel, input logic [15:0] addr, input int n,
                          input logic [7:0] d0, input logic exp_hdr, input logic exp_data,
                          input string req);
    logic a, o;
    i2c_start();
    send_byte(sel, a, o);            chk({req, " select ack"}, a, exp_hdr);
    send_byte(addr[15:8], a, o);     chk({req, " addr hi ack"}, a, exp_hdr);
    send_byte(addr[7:0], a, o);      chk({req, " addr lo ack"}, a, exp_hdr);
    for (int i = 0; i < n; i++) begin
      if (exp_data) exp_q.push_back({addr[15:2], 2'(addr[1:0] + i), 8'(d0 + i)});
      send_byte(8'(d0 + i), a, o);
      chk({req, " data ack"}, a, exp_data);
    end
  endtask

  task automatic chk_commits(input string req);
    wq(4*Q);
    chk({req, " commit count"}, commits_seen, commits_exp);
    chk({req, " scoreboard drained"}, exp_q.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic a, o;
    wq(5);
    rst_n = 1'b1;
    wq(2);
    // R1
    chk("R1 sda_oe reset", sda_oe, 0);
    chk("R1 wr_vld reset", vld, 0);
    chk("R1 commit reset", commit, 0);

    // R2 R3 R4 R7 R11: plain 3-byte write; select = 1010_101_0
    i2c_start();
    send_byte(8'hAA, a, o);
    chk("R2 select ack", a, 1);
    chk("R11 ack released after 9th fall", o, 0);
    send_byte(8'h12, a, o); chk("R3 addr hi ack", a, 1);
    send_byte(8'h30, a, o); chk("R3 addr lo ack", a, 1);
    for (int i = 0; i < 3; i++) begin
      exp_q.push_back({16'h1230 + 16'(i), 8'h40 + 8'(i)});
      send_byte(8'h40 + 8'(i), a, o);
      chk("R4 data ack", a, 1);
    end
    i2c_stop(); commits_exp++;
    chk_commits("R7 basic");

    // R4 roll-over within 4-byte page
    do_write(8'hAA, 16'h0456, 5, 8'h80, 1, 1, "R4 rollover");
    i2c_stop(); commits_exp++;
    chk_commits("R4 rollover");

    // R2 wrong chip address, then read bit set
    do_write(8'hA0, 16'h0001, 1, 8'h11, 0, 0, "R2 chip mismatch");
    i2c_stop();
    chk_commits("R2 chip mismatch");
    do_write(8'hAB, 16'h0001, 1, 8'h11, 0, 0, "R2 read bit");
    i2c_stop();
    chk_commits("R2 read bit");

    // R5 protect pulse only during select byte
    wp = 1'b1;
    i2c_start();
    send_byte(8'hAA, a, o); chk("R5 select ack", a, 1);
    wp = 1'b0;
    send_byte(8'h00, a, o); chk("R5 addr hi ack", a, 1);
    send_byte(8'h10, a, o); chk("R5 addr lo ack", a, 1);
    send_byte(8'h55, a, o); chk("R5 data noack", a, 0);
    send_byte(8'h56, a, o); chk("R5 data noack", a, 0);
    i2c_stop();
    chk_commits("R5 protected");

    // R6 protect only after address phase
    i2c_start();
    send_byte(8'hAA, a, o);
    send_byte(8'h00, a, o);
    send_byte(8'h21, a, o);
    wp = 1'b1;
    exp_q.push_back({16'h0021, 8'h77});
    send_byte(8'h77, a, o); chk("R6 late wp data ack", a, 1);
    i2c_stop(); commits_exp++;
    wp = 1'b0;
    chk_commits("R6 late wp");

    // R8 stop mid-byte, and stop right after address
    do_write(8'hAA, 16'h0300, 1, 8'h33, 1, 1, "R8 midbyte");
    send_bits(8'h00, 3);
    i2c_stop();
    chk_commits("R8 stop mid-byte");
    do_write(8'hAA, 16'h0300, 0, 8'h00, 1, 1, "R8 no data");
    i2c_stop();
    chk_commits("R8 stop after address");

    // R9 repeated start discards, new transfer commits once
    do_write(8'hAA, 16'h0500, 2, 8'h60, 1, 1, "R9 first part");
    do_write(8'hAA, 16'h0700, 1, 8'h90, 1, 1, "R9 after restart");
    i2c_stop(); commits_exp++;
    chk_commits("R9 repeated start");

    // R10 busy: silent bus
    busy = 1'b1;
    do_write(8'hAA, 16'h0800, 2, 8'h01, 0, 0, "R10 busy");
    i2c_stop();
    chk_commits("R10 busy");
    busy = 1'b0;
    wq(Q);

    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule